// File: doc/BRIEF.md
# Halt/Idle Power-Save Controller

This controller moves a small processor core between normal execution and two low-power states. A light sleep state, called idle, keeps the oscillator and the always-on timer T0 alive. A deep sleep state, called halt, stops every clock, including the oscillator. The controller drives gating enables for the core clock, the general timers, the oscillator and T0. It also tells the watchdog to stand down while halted, and it can pull the watchdog fault pin low when the clock monitor sees the stopped clock.

Software requests a state by pulsing `halt_set` or `idle_set` while the core runs. Idle ends on a T0 periodic tick or on a pending wakeup from the wakeup port. Halt ends on a pending wakeup or on a rising edge of the clock-output pin. A halt exit first passes through an oscillator warm-up window of `WARM_CYCLES` cycles, with the core clock still gated, and only then returns to run. The halt and idle flags read back high only while their state is active, so they clear on their own when the state is left.

Top module: `psave_ctrl`

## Requirements
- R1: After reset the controller is in run: the core, timer, oscillator and T0 enables are 1, `wdog_dis` is 0, `wdog_flt_n` is 1, and both flags are 0.
- R2: A `halt_set` pulse in run enters halt on the next clock. All four enables are then 0, `halt_flag` is 1 and `wdog_dis` is 1.
- R3: An `idle_set` pulse in run enters idle on the next clock. In idle only `osc_en` and `t0_en` are 1, `idle_flag` is 1, and the state holds until an exit event arrives.
- R4: When `halt_set` and `idle_set` are both high in the same run cycle, halt is entered and `idle_flag` stays 0.
- R5: While halted, `wdog_flt_n` equals the inverse of `cmon_en`. Outside halt, `wdog_flt_n` is 1.
- R6: `wake_pend` during halt starts warm-up on the next clock. During warm-up only `osc_en` is 1 and both flags are 0. Warm-up lasts exactly 256 cycles (default `WARM_CYCLES`), and run follows.
- R7: A rising edge on `cko_pin` exits halt into warm-up on the third clock after the pin rises (two synchronizer stages plus the state update). A pin level that was already high when halt was entered causes no exit.
- R8: In idle, `t0_tick` or `wake_pend` returns the controller directly to run on the next clock, with `idle_flag` cleared.
- R9: `wake_pend` and `t0_tick` have no effect while in run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_set | input | 1 | Software write of 1 to the halt flag |
| idle_set | input | 1 | Software idle request |
| wake_pend | input | 1 | Pending event from the wakeup port |
| cko_pin | input | 1 | Clock-output pin level, asynchronous |
| cmon_en | input | 1 | Clock monitor enable |
| t0_tick | input | 1 | Periodic event from timer T0 |
| core_clk_en | output | 1 | Core clock gate enable |
| timer_clk_en | output | 1 | General timer clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| t0_en | output | 1 | Always-on timer T0 enable |
| wdog_dis | output | 1 | Watchdog suspend, high while halted |
| wdog_flt_n | output | 1 | Watchdog fault output, active low |
| halt_flag | output | 1 | Halt flag readback |
| idle_flag | output | 1 | Idle flag readback |

## Verification
The two requests that can land in the same cycle are a halt write and an idle request. The bench raises both on one falling edge while the core runs, with the clock monitor enabled. It expects the full halt output pattern one clock later: every enable low, the halt flag high, the idle flag low and the fault pin low. A second coincidence, a T0 tick together with a wakeup during run, must leave the run pattern unchanged.

// File: rtl/psave_ctrl.sv
module psave_ctrl #(
  parameter int WARM_CYCLES = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_set,
  input  logic idle_set,
  input  logic wake_pend,
  input  logic cko_pin,
  input  logic cmon_en,
  input  logic t0_tick,
  output logic core_clk_en,
  output logic timer_clk_en,
  output logic osc_en,
  output logic t0_en,
  output logic wdog_dis,
  output logic wdog_flt_n,
  output logic halt_flag,
  output logic idle_flag
);
  localparam int CW = (WARM_CYCLES > 1) ? $clog2(WARM_CYCLES) : 1;
  localparam logic [CW-1:0] WLAST = CW'(WARM_CYCLES - 1);

  typedef enum logic [1:0] {S_RUN, S_IDLE, S_HALT, S_WARM} st_t;

  st_t state, nxt;
  logic [CW-1:0] wcnt;
  logic [SYNC_STAGES-1:0] cko_sync;
  logic cko_prev;
  logic cko_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cko_sync <= '0;
      cko_prev <= 1'b0;
    end else begin
      cko_sync <= {cko_sync[SYNC_STAGES-2:0], cko_pin};
      cko_prev <= cko_sync[SYNC_STAGES-1];
    end
  end

  assign cko_rise = cko_sync[SYNC_STAGES-1] & ~cko_prev;

  always_comb begin
    nxt = state;
    case (state)
      S_RUN:  if (halt_set) nxt = S_HALT;
              else if (idle_set) nxt = S_IDLE;
      S_IDLE: if (t0_tick || wake_pend) nxt = S_RUN;
      S_HALT: if (wake_pend || cko_rise) nxt = S_WARM;
      S_WARM: if (wcnt == WLAST) nxt = S_RUN;
      default: nxt = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_RUN;
      wcnt  <= '0;
    end else begin
      state <= nxt;
      wcnt  <= (state == S_WARM) ? wcnt + 1'b1 : '0;
    end
  end

  assign core_clk_en  = (state == S_RUN);
  assign timer_clk_en = (state == S_RUN);
  assign osc_en       = (state != S_HALT);
  assign t0_en        = (state == S_RUN) || (state == S_IDLE);
  assign wdog_dis     = (state == S_HALT);
  assign wdog_flt_n   = !((state == S_HALT) && cmon_en);
  assign halt_flag    = (state == S_HALT);
  assign idle_flag    = (state == S_IDLE);

  // R2
  halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && halt_set) |=> (halt_flag && wdog_dis && !osc_en));

  // R4
  halt_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && halt_set && idle_set) |=> (!idle_flag && halt_flag));

  // R5
  flt_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wdog_flt_n |-> (wdog_dis && cmon_en));

  // R6
  warm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WARM && wcnt != WLAST) |=> (!core_clk_en && osc_en));

  // R6
  halt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_flag && wake_pend) |=> (!halt_flag && !core_clk_en && osc_en));

  // R8
  idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_flag && (t0_tick || wake_pend)) |=> (core_clk_en && !idle_flag));

  // R9
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && !halt_set && !idle_set) |=> core_clk_en);

  // R2
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_flag && idle_flag));
endmodule

// File: tb/psave_ctrl_test.sv
`timescale 1ns/1ps
module psave_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_set = 1'b0, idle_set = 1'b0, wake_pend = 1'b0;
  logic cko_pin = 1'b0, cmon_en = 1'b0, t0_tick = 1'b0;
  logic core_clk_en, timer_clk_en, osc_en, t0_en, wdog_dis, wdog_flt_n, halt_flag, idle_flag;

  always #5 clk = ~clk;

  psave_ctrl uut (
    .clk(clk), .rst_n(rst_n), .halt_set(halt_set), .idle_set(idle_set),
    .wake_pend(wake_pend), .cko_pin(cko_pin), .cmon_en(cmon_en), .t0_tick(t0_tick),
    .core_clk_en(core_clk_en), .timer_clk_en(timer_clk_en), .osc_en(osc_en),
    .t0_en(t0_en), .wdog_dis(wdog_dis), .wdog_flt_n(wdog_flt_n),
    .halt_flag(halt_flag), .idle_flag(idle_flag)
  );

  // {core, timer, osc, t0, wdog_dis, flt_n, halt_flag, idle_flag}
  localparam logic [7:0] P_RUN   = 8'b1111_0100;
  localparam logic [7:0] P_IDLE  = 8'b0011_0101;
  localparam logic [7:0] P_HALTC = 8'b0000_1010;
  localparam logic [7:0] P_HALTN = 8'b0000_1110;
  localparam logic [7:0] P_WARM  = 8'b0010_0100;

  typedef struct {
    int          cyc;
    logic [7:0]  val;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;

  task automatic exp_at(input int d, input logic [7:0] v, input string tag);
    item_t it;
    it.cyc = cyc + d;
    it.val = v;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  always begin
    @(posedge clk);
    cyc = cyc + 1;
    #2;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc <= cyc) begin
        logic [7:0] act;
        act = {core_clk_en, timer_clk_en, osc_en, t0_en, wdog_dis, wdog_flt_n, halt_flag, idle_flag};
        checks++;
        if (q[i].cyc < cyc || act !== q[i].val) begin
          errors++;
          $display("FAIL %s cycle %0d: actual=%b expected=%b", q[i].tag, cyc, act, q[i].val);
        end
        q.delete(i);
      end
    end
  end

  task automatic drive_all;
    wait_n(3);
    rst_n = 1'b1;
    exp_at(1, P_RUN, "R1 reset state");
    wait_n(2);

    halt_set = 1'b1; idle_set = 1'b1; cmon_en = 1'b1;
    exp_at(1, P_HALTC, "R4 halt wins over idle, R5 fault low");
    wait_n(1);
    halt_set = 1'b0; idle_set = 1'b0; cmon_en = 1'b0;
    exp_at(1, P_HALTN, "R5 monitor off keeps fault high");
    wait_n(2);

    wake_pend = 1'b1;
    exp_at(1, P_WARM, "R6 warm-up start");
    exp_at(256, P_WARM, "R6 last warm-up cycle");
    exp_at(257, P_RUN, "R6 run after warm-up");
    wait_n(1);
    wake_pend = 1'b0;
    wait_n(260);

    wake_pend = 1'b1; t0_tick = 1'b1;
    exp_at(1, P_RUN, "R9 events ignored in run");
    wait_n(1);
    wake_pend = 1'b0; t0_tick = 1'b0;
    exp_at(1, P_RUN, "R9 still running");
    wait_n(2);

    cko_pin = 1'b1;
    wait_n(4);
    halt_set = 1'b1;
    exp_at(1, P_HALTN, "R2 halt entry");
    wait_n(1);
    halt_set = 1'b0;
    exp_at(8, P_HALTN, "R7 high level at entry no exit");
    wait_n(8);
    cko_pin = 1'b0;
    wait_n(4);
    exp_at(1, P_HALTN, "R7 falling pin no exit");
    cko_pin = 1'b1;
    exp_at(2, P_HALTN, "R7 edge still in synchronizer");
    exp_at(3, P_WARM, "R7 rising pin exits halt");
    exp_at(258, P_WARM, "R7 warm-up last cycle");
    exp_at(259, P_RUN, "R7 run after warm-up");
    wait_n(262);
    cko_pin = 1'b0;

    idle_set = 1'b1;
    exp_at(1, P_IDLE, "R3 idle entry");
    wait_n(1);
    idle_set = 1'b0;
    exp_at(4, P_IDLE, "R3 idle holds");
    wait_n(4);
    t0_tick = 1'b1;
    exp_at(1, P_RUN, "R8 T0 tick exits idle");
    wait_n(1);
    t0_tick = 1'b0;
    idle_set = 1'b1;
    exp_at(1, P_IDLE, "R3 idle re-entry");
    wait_n(1);
    idle_set = 1'b0;
    wake_pend = 1'b1;
    exp_at(1, P_RUN, "R8 wakeup exits idle");
    wait_n(1);
    wake_pend = 1'b0;
    wait_n(4);
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    fork
      drive_all();
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    if (q.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL pending expectations: actual=%0d expected=0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule